// File: doc/BRIEF.md
# Alarm Match and Wakeup Controller

This block watches a running time value, made of several equal-width fields, and compares it with a programmed alarm value. A per-field mask can leave chosen fields out of the comparison. A registered match output follows the comparison in the slow counter clock domain. When the counter advances once per second, the output stays high for the whole second in which the alarm time is shown.

Each new match crosses into the bus clock domain. There it sets a sticky wakeup status bit. If wakeups are also enabled, it sets a wakeup output. Software clears both with a write to the control register, and the clear acts on the next bus clock edge. While the alarm is enabled, the alarm and mask registers are locked. Because of this lock, the multi-bit values never change while the counter domain is using them.

Top module: `alarm_wake_ctrl`

## Requirements
- R1: `match_out` is high only while the alarm enable (control bit 2, register address 0) is set and every unmasked field of `cur_time` equals the same field of the alarm value. It is low whenever the alarm enable is clear.
- R2: `match_out` stays high on every counter clock edge for as long as the match condition holds.
- R3: `match_out` changes only at a rising edge of `cnt_clk`. A new `cur_time` has no effect on it before that edge.
- R4: A match seen in the bus domain while the alarm is enabled sets `wake_status`. The bit stays set until software writes the control register with bit 0 set.
- R5: `wake_out` sets on a match only when both the alarm enable (bit 2) and the wake enable (bit 1) are set. `wake_out` is never high while `wake_status` is low.
- R6: A control write with bit 0 set clears `wake_status` and `wake_out` at the bus clock edge that accepts the write.
- R7: The alarm register (address 1, all bits) and the mask register (address 2, low bits) ignore writes while the alarm enable is set. The control register is writable at any time. Address 3 has no effect.
- R8: When a new match and a clear write fall in the same bus cycle, the set wins.
- R9: Each match sets the wakeup state once. A clear during a match that is still held does not re-arm it until the match ends and a new one begins.
- R10: Mask bit i set to 1 removes field i, which is bits [i*FIELD_W +: FIELD_W], from the equality check.
- R11: After reset, `match_out`, `wake_status` and `wake_out` are low, and the alarm, mask and control registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for register writes and wakeup state |
| cnt_clk | input | 1 | Slow counter clock for the comparison |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe, bus domain |
| wr_addr | input | 2 | Register select: 0 control, 1 alarm, 2 mask |
| wr_data | input | N_FIELDS*FIELD_W | Write data |
| cur_time | input | N_FIELDS*FIELD_W | Running time value, counter domain |
| match_out | output | 1 | Registered match, counter domain |
| wake_status | output | 1 | Sticky wakeup status, bus domain |
| wake_out | output | 1 | Wakeup output, bus domain |

## Verification
`match_out` is registered once from `cur_time`. The bench changes `cur_time` on a falling edge of `cnt_clk` and samples the output on the next falling edge. It also samples once just after the change, to confirm the output has not moved early.

An enable write needs two counter edges to cross into the counter domain. For this reason the bench waits four counter cycles after each enable or mask change before it checks anything.

The wakeup results arrive about three bus edges after `match_out` rises: two synchronizer stages and one set register. The bench therefore reads them six bus cycles later. A clear is due at the bus edge that takes the write, so the bench reads it on the falling edge right after that.

The near-exhaustive sweep covers every mask value against an exact time, a miss in each single field, and a miss in all fields.

// File: rtl/alarm_wake_pkg.sv
package alarm_wake_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTL   = 2'd0,
    SEL_ALARM = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Control register bit positions
  localparam int CTL_CLR_BIT   = 0;
  localparam int CTL_WAKE_BIT  = 1;
  localparam int CTL_ALARM_BIT = 2;

endpackage

// File: rtl/alarm_wake_sync.sv
module alarm_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/alarm_wake_regs.sv
module alarm_wake_regs
  import alarm_wake_pkg::*;
#(
  parameter int TIME_W   = 16,
  parameter int N_FIELDS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [TIME_W-1:0]   wr_data,
  output logic                alarm_en_o,
  output logic                wake_en_o,
  output logic                clr_pulse_o,
  output logic [TIME_W-1:0]   alarm_o,
  output logic [N_FIELDS-1:0] mask_o
);

  logic                alarm_en_q, wake_en_q;
  logic [TIME_W-1:0]   alarm_q;
  logic [N_FIELDS-1:0] mask_q;

  // Named write events for the assertions
  logic ctl_wr, alarm_wr, mask_wr, unlocked;

  assign unlocked = !alarm_en_q;
  assign ctl_wr   = wr_en && (reg_sel_e'(wr_addr) == SEL_CTL);
  assign alarm_wr = wr_en && (reg_sel_e'(wr_addr) == SEL_ALARM) && unlocked;
  assign mask_wr  = wr_en && (reg_sel_e'(wr_addr) == SEL_MASK)  && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_en_q <= 1'b0;
      wake_en_q  <= 1'b0;
      alarm_q    <= '0;
      mask_q     <= '0;
    end else begin
      if (ctl_wr) begin
        alarm_en_q <= wr_data[CTL_ALARM_BIT];
        wake_en_q  <= wr_data[CTL_WAKE_BIT];
      end
      if (alarm_wr) alarm_q <= wr_data;
      if (mask_wr)  mask_q  <= wr_data[N_FIELDS-1:0];
    end
  end

  assign alarm_en_o  = alarm_en_q;
  assign wake_en_o   = wake_en_q;
  assign alarm_o     = alarm_q;
  assign mask_o      = mask_q;
  assign clr_pulse_o = ctl_wr && wr_data[CTL_CLR_BIT];

  // R7: compare registers hold while the alarm is enabled
  a_r7_locked_while_enabled: assert property (
    @(posedge clk) disable iff (!rst_n)
    alarm_en_q |=> ($stable(alarm_q) && $stable(mask_q))
  );

endmodule

// File: rtl/alarm_wake_cmp.sv
module alarm_wake_cmp #(
  parameter int FIELD_W  = 4,
  parameter int N_FIELDS = 4,
  localparam int TIME_W  = FIELD_W * N_FIELDS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [TIME_W-1:0]   cur_time_i,
  input  logic [TIME_W-1:0]   alarm_i,
  input  logic [N_FIELDS-1:0] mask_i,
  output logic                match_o
);

  logic [N_FIELDS-1:0] field_ok;
  logic                hit;
  logic                match_q;

  function automatic logic fields_agree(logic [N_FIELDS-1:0] ok);
    return &ok;
  endfunction

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    assign field_ok[f] = mask_i[f] ||
      (cur_time_i[f*FIELD_W +: FIELD_W] == alarm_i[f*FIELD_W +: FIELD_W]);
  end

  assign hit = en_i && fields_agree(field_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= hit;
  end

  assign match_o = match_q;

  // R1: no match out while the (synchronized) enable is low
  a_r1_off_no_match: assert property (
    @(posedge clk) disable iff (!rst_n)
    !en_i |=> !match_q
  );

endmodule

// File: rtl/alarm_wake_sticky.sv
module alarm_wake_sticky #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match_sync_i,
  input  logic alarm_en_i,
  input  logic wake_en_i,
  input  logic clr_i,
  output logic status_o,
  output logic wake_o
);

  logic seen_q;
  logic set_evt;
  logic status_q, wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= match_sync_i;
  end

  assign set_evt = match_sync_i && !seen_q && alarm_en_i;

  // Set has priority over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      if (set_evt)    status_q <= 1'b1;
      else if (clr_i) status_q <= 1'b0;

      if (set_evt && wake_en_i) wake_q <= 1'b1;
      else if (clr_i)           wake_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign wake_o   = wake_q;

  // R4: status is sticky without a clear
  a_r4_sticky: assert property (
    @(posedge clk) disable iff (!rst_n)
    (status_q && !clr_i) |=> status_q
  );

  // R5: wakeup output never without status, rises only with wake enable
  a_r5_out_implies_status: assert property (
    @(posedge clk) disable iff (!rst_n)
    wake_q |-> status_q
  );
  a_r5_rise_needs_wake_en: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(wake_q) |-> $past(wake_en_i)
  );

  // R6: a clear alone drops both at the next edge
  a_r6_clear_drops: assert property (
    @(posedge clk) disable iff (!rst_n)
    (clr_i && !set_evt) |=> (!status_q && !wake_q)
  );

  // R8: set wins over a simultaneous clear
  a_r8_set_wins: assert property (
    @(posedge clk) disable iff (!rst_n)
    set_evt |=> status_q
  );

  // R9: one set event per crossed match edge
  a_r9_single_set: assert property (
    @(posedge clk) disable iff (!rst_n)
    set_evt |=> !set_evt
  );

endmodule

// File: rtl/alarm_wake_ctrl.sv
module alarm_wake_ctrl
  import alarm_wake_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int N_FIELDS    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int TIME_W     = FIELD_W * N_FIELDS
) (
  input  logic              bus_clk,
  input  logic              cnt_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TIME_W-1:0] wr_data,
  input  logic [TIME_W-1:0] cur_time,
  output logic              match_out,
  output logic              wake_status,
  output logic              wake_out
);

  logic                alarm_en_bus, wake_en_bus, clr_pulse;
  logic [TIME_W-1:0]   alarm_val;
  logic [N_FIELDS-1:0] mask_val;
  logic                alarm_en_cnt;
  logic                match_cnt, match_bus;

  alarm_wake_regs #(.TIME_W(TIME_W), .N_FIELDS(N_FIELDS)) u_regs (
    .clk         (bus_clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .alarm_en_o  (alarm_en_bus),
    .wake_en_o   (wake_en_bus),
    .clr_pulse_o (clr_pulse),
    .alarm_o     (alarm_val),
    .mask_o      (mask_val)
  );

  alarm_wake_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk   (cnt_clk),
    .rst_n (rst_n),
    .d_i   (alarm_en_bus),
    .q_o   (alarm_en_cnt)
  );

  alarm_wake_cmp #(.FIELD_W(FIELD_W), .N_FIELDS(N_FIELDS)) u_cmp (
    .clk        (cnt_clk),
    .rst_n      (rst_n),
    .en_i       (alarm_en_cnt),
    .cur_time_i (cur_time),
    .alarm_i    (alarm_val),
    .mask_i     (mask_val),
    .match_o    (match_cnt)
  );

  alarm_wake_sync #(.STAGES(SYNC_STAGES)) u_match_sync (
    .clk   (bus_clk),
    .rst_n (rst_n),
    .d_i   (match_cnt),
    .q_o   (match_bus)
  );

  alarm_wake_sticky #(.SYNC_STAGES(SYNC_STAGES)) u_sticky (
    .clk          (bus_clk),
    .rst_n        (rst_n),
    .match_sync_i (match_bus),
    .alarm_en_i   (alarm_en_bus),
    .wake_en_i    (wake_en_bus),
    .clr_i        (clr_pulse),
    .status_o     (wake_status),
    .wake_o       (wake_out)
  );

  assign match_out = match_cnt;

endmodule

// File: tb/alarm_wake_ctrl_tb_top.sv
module alarm_wake_ctrl_tb_top;

  localparam int FW = 4;
  localparam int NF = 4;
  localparam int TW = FW * NF;
  localparam logic [TW-1:0] ALM = 16'hA5C3;

  logic          bus_clk = 1'b0, cnt_clk = 1'b0, rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [TW-1:0] wr_data = '0, cur_time = '0;
  logic          match_out, wake_status, wake_out;

  int checks = 0, errors = 0;

  always #4  bus_clk = ~bus_clk;   // 125 MHz
  always #28 cnt_clk = ~cnt_clk;   // slow counter clock

  alarm_wake_ctrl #(.FIELD_W(FW), .N_FIELDS(NF), .SYNC_STAGES(2)) dut_i (
    .bus_clk, .cnt_clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .cur_time, .match_out, .wake_status, .wake_out
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [TW-1:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic cnt_wait(int n);
    repeat (n) @(negedge cnt_clk);
  endtask

  task automatic bus_wait(int n);
    repeat (n) @(negedge bus_clk);
  endtask

  // present a time value and sample match one counter edge later
  task automatic show(logic [TW-1:0] t);
    @(negedge cnt_clk);
    cur_time = t;
    @(negedge cnt_clk);
  endtask

  function automatic int expect_hit(logic [TW-1:0] t, logic [TW-1:0] a, int msk, int en);
    int ok = en;
    for (int f = 0; f < NF; f++) begin
      int ft = int'(t >> (f * FW)) % (1 << FW);
      int fa = int'(a >> (f * FW)) % (1 << FW);
      if (((msk >> f) % 2) == 0 && ft != fa) ok = 0;
    end
    return ok;
  endfunction

  initial begin
    repeat (200000) @(posedge bus_clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int highs;
    repeat (3) @(negedge bus_clk);
    rst_n = 1'b1;
    cnt_wait(2);
    // R11: reset state
    chk("R11 match_out", match_out, 0);
    chk("R11 wake_status", wake_status, 0);
    chk("R11 wake_out", wake_out, 0);

    // R1 with alarm disabled: alarm reg 0 equals time 0 but no match
    show('0);
    chk("R1 disabled no match", match_out, 0);

    bus_wr(2'd1, ALM);

    // R10/R1 sweep: every mask, six time patterns
    for (int m = 0; m < (1 << NF); m++) begin
      bus_wr(2'd0, 16'h0000);
      bus_wr(2'd2, TW'(m));
      bus_wr(2'd0, 16'h0004);
      cnt_wait(4);
      for (int p = 0; p < NF + 2; p++) begin
        logic [TW-1:0] t;
        if (p == 0)       t = ALM;
        else if (p <= NF) t = ALM ^ (TW'(1) << ((p - 1) * FW));
        else              t = ALM ^ 16'h1111;
        show(t);
        chk($sformatf("R10 mask %0d pattern %0d", m, p), match_out,
            expect_hit(t, ALM, m, 1));
      end
    end

    // R7: locked writes while enabled (mask currently 4'hF)
    bus_wr(2'd0, 16'h0000);
    bus_wr(2'd2, 16'h0000);
    bus_wr(2'd0, 16'h0004);
    cnt_wait(4);
    bus_wr(2'd1, 16'h1234);
    bus_wr(2'd2, 16'h000F);
    bus_wr(2'd3, 16'hFFFF);
    show(16'h1234);
    chk("R7 alarm write ignored (new value)", match_out, 0);
    show(ALM);
    chk("R7 alarm write ignored (old value)", match_out, 1);
    show(ALM ^ 16'h0100);
    chk("R7 mask write ignored", match_out, 0);

    // R3: no change before the counter edge
    @(negedge cnt_clk);
    cur_time = ALM;
    #4;
    chk("R3 no early change", match_out, 0);
    @(negedge cnt_clk);
    chk("R3 change at edge", match_out, 1);
    // R2: held for the whole period of the match
    for (int k = 0; k < 4; k++) begin
      @(negedge cnt_clk);
      chk("R2 held while true", match_out, 1);
    end

    // wakeup with both enables
    show(16'h0000);
    bus_wr(2'd0, 16'h0007);
    bus_wait(1);
    chk("R6 cleared before test", wake_status, 0);
    chk("R6 wake_out cleared before test", wake_out, 0);
    show(ALM);
    chk("R4 match present", match_out, 1);
    bus_wait(6);
    chk("R4 status set", wake_status, 1);
    chk("R5 wake_out set", wake_out, 1);
    cnt_wait(2);
    chk("R4 status sticky", wake_status, 1);
    // R6: clear while match still held
    bus_wr(2'd0, 16'h0007);
    chk("R6 status cleared", wake_status, 0);
    chk("R6 wake_out cleared", wake_out, 0);
    cnt_wait(3);
    chk("R9 no re-set on held match", wake_status, 0);
    chk("R9 match still high", match_out, 1);
    show(16'h0000);
    cnt_wait(1);
    chk("R9 idle after match ends", wake_status, 0);
    show(ALM);
    bus_wait(6);
    chk("R9 new match sets again", wake_status, 1);

    // R5: wake enable off
    show(16'h0000);
    bus_wr(2'd0, 16'h0005);
    cnt_wait(2);
    show(ALM);
    bus_wait(6);
    chk("R5 status without wake enable", wake_status, 1);
    chk("R5 no wake_out without wake enable", wake_out, 0);

    // R1/R4: alarm disabled gives neither match nor status
    show(16'h0000);
    bus_wr(2'd0, 16'h0001);
    cnt_wait(4);
    show(ALM);
    cnt_wait(2);
    chk("R1 disabled no match", match_out, 0);
    chk("R4 disabled no status", wake_status, 0);

    // R8: clear held every cycle while a match arrives
    show(16'h0000);
    bus_wr(2'd0, 16'h0006);
    cnt_wait(4);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0007;
    @(negedge cnt_clk);
    cur_time = ALM;
    highs = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge bus_clk);
      if (wake_status) highs++;
    end
    wr_en = 1'b0;
    chk("R8 set seen for one cycle under held clear", highs, 1);
    bus_wait(2);
    chk("R8 status after clear released", wake_status, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule